// File: doc/BRIEF.md
# CRC Memory Scrubber with Serial Signature Readout

The block sweeps a small configuration memory held in registers, one 32-bit word per checker clock. It folds each word into a running CRC and, at the end of every sweep, compares the finished signature against a reference CRC fixed when the block is built. A mismatch sets a sticky error flag. A one-cycle completion pulse marks the end of every sweep. Both flags belong to the checker clock domain.

A second clock, owned by the user, drives a 32-bit readout shift register. With the shift/load control low, the register loads in parallel either the reference CRC or the latest complete signature. With the control high, it shifts toward bit 0 one place per user clock, so the bits can be collected serially.

A completed signature crosses into the user domain through a toggle strobe and a two-flop synchronizer. A test port can invert any single memory bit to provoke a mismatch.

Top module: `crc_scrubber`

## Requirements
- R1: While `chk_rst` is high, `crc_err` and `sweep_done` are low after the first checker edge. While `usr_rst` is high, `dout` is low after the first user edge.
- R2: After `chk_rst`, memory word i holds `SEED ^ (i * 32'h9E3779B9)`, with the product truncated to 32 bits. The reference CRC is the signature of that content.
- R3: The signature is the reflected CRC-32 over words 0 to DEPTH-1 in address order. It uses polynomial 32'hEDB88320, an initial value of all ones and a final XOR with all ones, and takes the bits of each word LSB first.
- R4: `sweep_done` is high for exactly one checker cycle per sweep, and consecutive pulses are DEPTH checker cycles apart.
- R5: `crc_err` rises in the same checker cycle as the `sweep_done` pulse of a sweep whose signature differs from the reference. A matching sweep does not raise it.
- R6: Once set, `crc_err` stays high through later matching sweeps until `chk_rst`.
- R7: When `flip_en` is high on a checker edge, bit `flip_bit` of word `flip_addr` is inverted.
- R8: With `shift_n_load` = 0, the readout register loads on the rising `usr_clk` edge. It loads the reference CRC when `ld_sel` = 0 and the latest complete signature when `ld_sel` = 1.
- R9: While `shift_n_load` = 1, `ld_sel` has no effect.
- R10: After a load, `dout` shows bit 0. Each user cycle with `shift_n_load` = 1 moves the next higher bit to `dout`, so 31 shifts present all 32 bits. Zeros fill from the top.
- R11: The readout only ever sees signatures of complete sweeps. On the user cycle in which a new signature is taken over, a parallel load is suppressed and the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_clk | input | 1 | Checker clock |
| chk_rst | input | 1 | Synchronous active-high reset, checker domain |
| flip_en | input | 1 | Test strobe: invert one memory bit |
| flip_addr | input | $clog2(DEPTH) | Word to corrupt |
| flip_bit | input | 5 | Bit position within that word |
| crc_err | output | 1 | Sticky mismatch flag (checker domain) |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse (checker domain) |
| usr_clk | input | 1 | User readout clock |
| usr_rst | input | 1 | Synchronous active-high reset, user domain |
| shift_n_load | input | 1 | 1 = shift, 0 = parallel load |
| ld_sel | input | 1 | Load source: 0 reference, 1 computed signature |
| dout | output | 1 | Serial readout bit (registered) |

## Verification
The bench builds the block with DEPTH = 32 and SEED = 32'hC0DE5EED. That gives a 128 ns sweep against a 7 ns user clock, so many sweeps complete, and a readout can be started well clear of the next signature hand-over. The short memory puts both end words in easy reach: bit 0 of word 0 and bit 31 of word 31 are corrupted and then restored. This exercises first-word seeding of the CRC, last-word signature capture and the persistence of the error flag. Each readout is checked bit by bit against a CRC that the bench computes from its own copy of the memory.

// File: rtl/crc_scrub_pkg.sv
package crc_scrub_pkg;
  localparam int          WORD_W     = 32;
  localparam int          BIT_AW     = $clog2(WORD_W);
  localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOROUT = 32'hFFFF_FFFF;
  localparam logic [31:0] FILL_STEP  = 32'h9E37_79B9;

  // Fold one word into a reflected CRC, least significant bit first.
  function automatic logic [31:0] crc_fold_word(input logic [31:0] crc_in,
                                                input logic [31:0] word);
    logic [31:0] c;
    c = crc_in;
    for (int b = 0; b < WORD_W; b++) begin
      if (c[0] ^ word[b]) c = (c >> 1) ^ CRC_POLY;
      else                c = c >> 1;
    end
    return c;
  endfunction

  // Content loaded into the memory on reset.
  function automatic logic [31:0] fill_word(input int unsigned idx,
                                            input logic [31:0] seed);
    return seed ^ (32'(idx) * FILL_STEP);
  endfunction

  // Golden signature of the reset content, evaluated at elaboration.
  function automatic logic [31:0] golden_signature(input int unsigned depth,
                                                   input logic [31:0] seed);
    logic [31:0] c;
    c = CRC_INIT;
    for (int unsigned i = 0; i < depth; i++) c = crc_fold_word(c, fill_word(i, seed));
    return c ^ CRC_XOROUT;
  endfunction
endpackage

// File: rtl/crc_cfg_mem.sv
module crc_cfg_mem
  import crc_scrub_pkg::*;
#(
  parameter int          DEPTH = 64,
  parameter logic [31:0] SEED  = 32'h1234_5678,
  localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              flip_en,
  input  logic [AW-1:0]     flip_addr,
  input  logic [BIT_AW-1:0] flip_bit
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= fill_word(i, SEED);
    end else if (flip_en && (int'(flip_addr) < DEPTH)) begin
      mem_q[flip_addr][flip_bit] <= ~mem_q[flip_addr][flip_bit];
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    rd_data <= mem_q[rd_addr];
  end
endmodule

// File: rtl/crc_sweep_seq.sv
module crc_sweep_seq #(
  parameter int  DEPTH = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          rd_first,
  output logic          rd_last
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      rd_valid <= 1'b0;
      rd_first <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      addr_q   <= (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
      // Flags travel alongside the one-cycle memory read latency.
      rd_valid <= 1'b1;
      rd_first <= (addr_q == '0);
      rd_last  <= (addr_q == LAST_ADDR);
    end
  end

  assign rd_addr = addr_q;
endmodule

// File: rtl/crc_sweep_engine.sv
module crc_sweep_engine
  import crc_scrub_pkg::*;
#(
  parameter logic [31:0] REF_CRC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic              rd_first,
  input  logic              rd_last,
  input  logic [WORD_W-1:0] rd_data,
  output logic [31:0]       sig_hold,
  output logic              upd_tgl,
  output logic              done,
  output logic              err
);
  logic [31:0] acc_q;
  logic [31:0] acc_base;
  logic [31:0] acc_next;
  logic [31:0] final_sig;

  always_comb begin
    acc_base  = rd_first ? CRC_INIT : acc_q;
    acc_next  = crc_fold_word(acc_base, rd_data);
    final_sig = acc_next ^ CRC_XOROUT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= CRC_INIT;
      sig_hold <= '0;
      upd_tgl  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_valid) begin
        acc_q <= acc_next;
        if (rd_last) begin
          // Only a finished signature is ever exposed.
          sig_hold <= final_sig;
          upd_tgl  <= ~upd_tgl;
          done     <= 1'b1;
          if (final_sig != REF_CRC) err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crc_sig_readout.sv
module crc_sig_readout #(
  parameter logic [31:0] REF_CRC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        upd_tgl,
  input  logic [31:0] sig_hold,
  input  logic        shift_n_load,
  input  logic        ld_sel,
  output logic        upd_pulse,
  output logic [31:0] sr_q
);
  logic        sync1_q, sync2_q, sync3_q;
  logic [31:0] sig_usr_q;

  assign upd_pulse = sync2_q ^ sync3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q   <= 1'b0;
      sync2_q   <= 1'b0;
      sync3_q   <= 1'b0;
      sig_usr_q <= '0;
      sr_q      <= '0;
    end else begin
      sync1_q <= upd_tgl;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
      if (upd_pulse) sig_usr_q <= sig_hold;
      if (!shift_n_load) begin
        if (!upd_pulse) sr_q <= ld_sel ? sig_usr_q : REF_CRC;
      end else begin
        sr_q <= {1'b0, sr_q[31:1]};
      end
    end
  end
endmodule

// File: rtl/crc_scrubber.sv
module crc_scrubber
  import crc_scrub_pkg::*;
#(
  parameter int          DEPTH = 64,
  parameter logic [31:0] SEED  = 32'h1234_5678,
  localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              chk_clk,
  input  logic              chk_rst,
  input  logic              flip_en,
  input  logic [AW-1:0]     flip_addr,
  input  logic [BIT_AW-1:0] flip_bit,
  output logic              crc_err,
  output logic              sweep_done,
  input  logic              usr_clk,
  input  logic              usr_rst,
  input  logic              shift_n_load,
  input  logic              ld_sel,
  output logic              dout
);
  localparam logic [31:0] REF_CRC = golden_signature(DEPTH, SEED);

  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic              rd_valid, rd_first, rd_last;
  logic [31:0]       sig_hold;
  logic              upd_tgl;
  logic              upd_pulse;
  logic [31:0]       sr_q;

  crc_cfg_mem #(.DEPTH(DEPTH), .SEED(SEED)) u_mem (
    .clk(chk_clk), .rst(chk_rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .flip_en(flip_en), .flip_addr(flip_addr), .flip_bit(flip_bit)
  );

  crc_sweep_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(chk_clk), .rst(chk_rst), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_first(rd_first), .rd_last(rd_last)
  );

  crc_sweep_engine #(.REF_CRC(REF_CRC)) u_eng (
    .clk(chk_clk), .rst(chk_rst), .rd_valid(rd_valid), .rd_first(rd_first),
    .rd_last(rd_last), .rd_data(rd_data), .sig_hold(sig_hold),
    .upd_tgl(upd_tgl), .done(sweep_done), .err(crc_err)
  );

  crc_sig_readout #(.REF_CRC(REF_CRC)) u_rd (
    .clk(usr_clk), .rst(usr_rst), .upd_tgl(upd_tgl), .sig_hold(sig_hold),
    .shift_n_load(shift_n_load), .ld_sel(ld_sel),
    .upd_pulse(upd_pulse), .sr_q(sr_q)
  );

  assign dout = sr_q[0];
endmodule

// File: rtl/crc_scrubber_chk.sv
module crc_scrubber_chk #(
  parameter logic [31:0] REF_CRC = 32'h0
) (
  input logic        chk_clk,
  input logic        chk_rst,
  input logic        usr_clk,
  input logic        usr_rst,
  input logic        crc_err,
  input logic        sweep_done,
  input logic        shift_n_load,
  input logic        ld_sel,
  input logic        upd_pulse,
  input logic [31:0] sr_q,
  input logic        dout
);
  // R1
  reset_clear_chk: assert property (@(posedge chk_clk)
    chk_rst |=> (!crc_err && !sweep_done));

  // R4
  done_single_chk: assert property (@(posedge chk_clk) disable iff (chk_rst)
    sweep_done |=> !sweep_done);

  // R5
  err_rise_chk: assert property (@(posedge chk_clk) disable iff (chk_rst)
    $rose(crc_err) |-> sweep_done);

  // R6
  err_sticky_chk: assert property (@(posedge chk_clk) disable iff (chk_rst)
    crc_err |=> crc_err);

  // R8
  load_ref_chk: assert property (@(posedge usr_clk) disable iff (usr_rst)
    (!shift_n_load && !ld_sel && !upd_pulse) |=> (sr_q == REF_CRC));

  // R10
  shift_step_chk: assert property (@(posedge usr_clk) disable iff (usr_rst)
    shift_n_load |=> (dout == $past(sr_q[1])));

  // R11
  load_block_chk: assert property (@(posedge usr_clk) disable iff (usr_rst)
    (!shift_n_load && upd_pulse) |=> $stable(sr_q));
endmodule

bind crc_scrubber crc_scrubber_chk #(.REF_CRC(REF_CRC)) u_chk (
  .chk_clk(chk_clk), .chk_rst(chk_rst), .usr_clk(usr_clk), .usr_rst(usr_rst),
  .crc_err(crc_err), .sweep_done(sweep_done), .shift_n_load(shift_n_load),
  .ld_sel(ld_sel), .upd_pulse(upd_pulse), .sr_q(sr_q), .dout(dout)
);

// File: tb/crc_scrubber_test.sv
module crc_scrubber_test;
  localparam int          DEPTH = 32;
  localparam logic [31:0] SEED  = 32'hC0DE_5EED;
  localparam int          AW    = $clog2(DEPTH);

  logic chk_clk = 1'b0, usr_clk = 1'b0;
  logic chk_rst = 1'b1, usr_rst = 1'b1;
  logic flip_en = 1'b0;
  logic [AW-1:0] flip_addr = '0;
  logic [4:0] flip_bit = '0;
  logic shift_n_load = 1'b1, ld_sel = 1'b0;
  logic crc_err, sweep_done, dout;

  int tests = 0, fails = 0;
  logic exp_q[$];
  string cur_req = "R10";
  logic [31:0] model_mem [DEPTH];
  logic [31:0] ref_sig;
  int gap = 0;
  bit have_prev = 0;

  always #2   chk_clk = ~chk_clk;  // 250 MHz checker clock
  always #3.5 usr_clk = ~usr_clk;

  crc_scrubber #(.DEPTH(DEPTH), .SEED(SEED)) uut (
    .chk_clk(chk_clk), .chk_rst(chk_rst), .flip_en(flip_en),
    .flip_addr(flip_addr), .flip_bit(flip_bit), .crc_err(crc_err),
    .sweep_done(sweep_done), .usr_clk(usr_clk), .usr_rst(usr_rst),
    .shift_n_load(shift_n_load), .ld_sel(ld_sel), .dout(dout)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_crc();
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < DEPTH; i++)
      for (int b = 0; b < 32; b++)
        c = (c[0] ^ model_mem[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return c ^ 32'hFFFF_FFFF;
  endfunction

  // Monitor: pops expected readout bits after each user edge.
  always @(posedge usr_clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic b;
      b = exp_q.pop_front();
      check(dout === b, cur_req, {31'b0, dout}, {31'b0, b});
    end
  end

  // Monitor: sweep pulse spacing and width (R4).
  always @(negedge chk_clk) begin
    if (chk_rst) begin
      have_prev = 0;
      gap = 0;
    end else begin
      gap++;
      if (sweep_done) begin
        if (have_prev) check(gap == DEPTH, "R4", gap, DEPTH);
        have_prev = 1;
        gap = 0;
      end
    end
  end

  // Driver: load, then shift 31 times, toggling ld_sel (R9).
  task automatic readout(input bit src, input logic [31:0] val, input string req);
    @(negedge usr_clk);
    cur_req = req;
    shift_n_load = 1'b0;
    ld_sel = src;
    for (int k = 0; k < 32; k++) exp_q.push_back(val[k]);
    repeat (31) begin
      @(negedge usr_clk);
      shift_n_load = 1'b1;
      ld_sel = ~ld_sel;
    end
    @(negedge usr_clk);
    while (exp_q.size() > 0) @(negedge usr_clk);
  endtask

  task automatic wait_done();
    do @(negedge chk_clk); while (!sweep_done);
  endtask

  // Two full sweeps, then clear of the signature hand-over.
  task automatic settle();
    wait_done();
    wait_done();
    repeat (6) @(negedge usr_clk);
  endtask

  task automatic flip(input int a, input int b);
    @(negedge chk_clk);
    flip_en = 1'b1;
    flip_addr = AW'(a);
    flip_bit = 5'(b);
    @(negedge chk_clk);
    flip_en = 1'b0;
    model_mem[a][b] = ~model_mem[a][b];
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model_mem[i] = SEED ^ (32'(i) * 32'h9E37_79B9);
    ref_sig = model_crc();

    repeat (4) @(negedge usr_clk);
    check(crc_err == 1'b0, "R1", {31'b0, crc_err}, 0);
    check(sweep_done == 1'b0, "R1", {31'b0, sweep_done}, 0);
    check(dout == 1'b0, "R1", {31'b0, dout}, 0);
    @(negedge chk_clk);
    chk_rst = 1'b0;
    @(negedge usr_clk);
    usr_rst = 1'b0;

    settle();
    check(crc_err == 1'b0, "R2", {31'b0, crc_err}, 0);
    readout(1'b1, ref_sig, "R3");
    readout(1'b0, ref_sig, "R8");

    // Corrupt the first word, lowest bit.
    flip(0, 0);
    settle();
    check(crc_err == 1'b1, "R5", {31'b0, crc_err}, 1);
    readout(1'b1, model_crc(), "R7");
    readout(1'b0, ref_sig, "R9");

    // Restore word 0, corrupt the last word's top bit.
    flip(0, 0);
    flip(DEPTH - 1, 31);
    settle();
    readout(1'b1, model_crc(), "R11");

    // Restore everything: flag must persist.
    flip(DEPTH - 1, 31);
    settle();
    check(crc_err == 1'b1, "R6", {31'b0, crc_err}, 1);
    readout(1'b1, ref_sig, "R11");

    @(negedge chk_clk);
    chk_rst = 1'b1;
    repeat (2) @(negedge chk_clk);
    check(crc_err == 1'b0, "R1", {31'b0, crc_err}, 0);
    chk_rst = 1'b0;
    settle();
    check(crc_err == 1'b0, "R6", {31'b0, crc_err}, 0);
    readout(1'b1, ref_sig, "R10");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule